// File: doc/BRIEF.md
# Quad DAC Write Command Decoder

This block sits behind a byte-level serial slave front end and turns write transactions into updates of a four-channel, 12-bit DAC register file. The front end presents a start strobe, a stop strobe, each received byte with a valid strobe, and an acknowledge strobe that marks the acknowledge slot of the byte just received. The decoder answers each byte with an acknowledge decision. It follows the framing that the command byte selects and, at the acknowledge slot of the closing byte of a channel group, commits that channel's reference select, two power-down bits, gain select and 12-bit code.

Six framings are decoded: fast write, multi-write, sequential write, single write, reference-select and gain-select. Sequential and single writes also send each committed channel word to a nonvolatile-store write port. Those two commands are refused while the store reports busy. Every commit raises a one-cycle update request for the channels whose outputs should follow the new register contents.

Top module: `dac_wcmd_dec`

## Requirements
- R1: After reset, every channel's reference, power-down, gain and code fields are zero, ack_o is low, and no update request or store write is pulsed.
- R2: After a start, an address byte equal to 1100 in bits 7:4, dev_addr_i in bits 3:1 and 0 in bit 0 is acknowledged. Any other address byte, including one with bit 0 set, is not acknowledged, and neither are the bytes that follow it up to the next start. None of them changes any register.
- R3: Fast write (command bits 7:6 = 00) fills channels 0,1,2,3 in turn from byte pairs. In the first byte, bits 5:4 are the power-down field and bits 3:0 are code bits 11:8. The second byte is code bits 7:0. Each pair commits power-down and code only, leaves reference and gain unchanged, requests an update of that channel and never writes the store.
- R4: Multi-write (bits 7:3 = 01000, channel in bits 2:1, no-update flag in bit 0) is followed by a field byte and a low code byte. The field byte holds reference in bit 7, power-down in bits 6:5, gain in bit 4 and code bits 11:8 in bits 3:0. A further select byte (channel in bits 2:1, flag in bit 0) may start another group. Multi-write never writes the store.
- R5: Sequential write (bits 7:3 = 01010) writes the field and code byte pairs from the channel in bits 2:1 up to channel 3. Each committed channel also pulses nv_wr_o with nv_ch_o set to the channel and nv_word_o set to {reference, power-down[1:0], gain, code[11:0]}. Bytes after channel 3 are not acknowledged.
- R6: Single write (bits 7:3 = 01011) writes one selected channel and its store copy as in R5. Bytes after its low code byte are not acknowledged.
- R7: Reference-select (bits 7:5 = 100) sets channel 0's reference from bit 3, channel 1's from bit 2, channel 2's from bit 1 and channel 3's from bit 0. It commits at that byte's acknowledge slot, requests an update of all four channels and does not write the store.
- R8: Gain-select (bits 7:5 = 110) sets the gain fields with the same bit-to-channel mapping and the same commit and update behaviour as R7.
- R9: For multi, sequential and single writes, upd_req_o pulses for the committed channel only when the no-update flag is 0.
- R10: A stop or a new start that arrives before the acknowledge slot of a group's last byte abandons that group: nothing is committed and no request is pulsed.
- R11: While nv_busy_i is high, a sequential or single command byte is not acknowledged and nothing in that transaction is committed. Multi-write is still acknowledged.
- R12: Registers, update requests and store writes change only in the cycle after an acknowledge strobe. Receiving a byte alone changes none of them.
- R13: Command bytes matching none of the six framings (for example 111xxxxx or 01001xxx) are not acknowledged, and nothing is committed until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_addr_i | input | 3 | Programmable device address bits |
| nv_busy_i | input | 1 | Nonvolatile store busy |
| start_i | input | 1 | Start or repeated-start strobe |
| stop_i | input | 1 | Stop strobe |
| byte_vld_i | input | 1 | Received byte valid strobe |
| byte_i | input | 8 | Received byte |
| ack_stb_i | input | 1 | Acknowledge slot strobe for the last byte |
| ack_o | output | 1 | Acknowledge decision for the last byte |
| vref_o | output | NCH | Reference select per channel |
| gain_o | output | NCH | Gain select per channel |
| pd_o | output | 2*NCH | Power-down field per channel |
| code_o | output | NCH*DW | Code per channel, channel 0 lowest |
| upd_req_o | output | NCH | One-cycle update request per channel |
| nv_wr_o | output | 1 | Store write pulse |
| nv_ch_o | output | CHW | Store write channel |
| nv_word_o | output | DW+4 | Store write word |

## Verification
The hardest condition to reach is a transaction cut off between bytes of one channel group. The stimulus has to place a stop, or a repeated start, after the field byte has been acknowledged but before the low code byte arrives. Directed tasks build that frame byte by byte, then open a fresh transaction to show the decoder resumes cleanly. A second case that is hard to reach is a commit deliberately held back: the low code byte is delivered, the acknowledge strobe is withheld for several cycles, and the register outputs are sampled in that gap.

// File: rtl/dac_wcmd_pkg.sv
package dac_wcmd_pkg;

  typedef enum logic [1:0] {
    CK_CHAN     = 2'd0,
    CK_VREF_ALL = 2'd1,
    CK_GAIN_ALL = 2'd2,
    CK_NONE     = 2'd3
  } commit_kind_e;

  typedef enum logic [3:0] {
    ST_IDLE = 4'd0,
    ST_ADDR = 4'd1,
    ST_SKIP = 4'd2,
    ST_CMD  = 4'd3,
    ST_FHI  = 4'd4,
    ST_FLO  = 4'd5,
    ST_CFG  = 4'd6,
    ST_LO   = 4'd7,
    ST_MSEL = 4'd8
  } frame_st_e;

  typedef enum logic [1:0] {
    FM_FAST   = 2'd0,
    FM_MULTI  = 2'd1,
    FM_SEQ    = 2'd2,
    FM_SINGLE = 2'd3
  } frame_mode_e;

endpackage

// File: rtl/dac_wcmd_fsm.sv
module dac_wcmd_fsm
  import dac_wcmd_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 12,
  parameter logic [3:0] DEV_CODE = 4'b1100,
  localparam int CHW = $clog2(NCH),
  localparam int HIW = DW - 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2:0]         dev_addr_i,
  input  logic               nv_busy_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               byte_vld_i,
  input  logic [7:0]         byte_i,
  input  logic               ack_stb_i,
  output logic               ack_o,
  output logic               commit_o,
  output commit_kind_e       cm_kind_o,
  output logic [CHW-1:0]     cm_ch_o,
  output logic               cm_cfg_o,
  output logic               cm_vref_o,
  output logic [1:0]         cm_pd_o,
  output logic               cm_gx_o,
  output logic [DW-1:0]      cm_data_o,
  output logic [NCH-1:0]     cm_bits_o,
  output logic               cm_udac_o,
  output logic               cm_nv_o
);

  frame_st_e         st;
  frame_mode_e       mode;
  logic [CHW-1:0]    ch;
  logic              udac;
  logic              h_vref;
  logic [1:0]        h_pd;
  logic              h_gx;
  logic [HIW-1:0]    h_hi;
  logic              ack_q;
  logic              pend_vld;
  commit_kind_e      p_kind;
  logic [CHW-1:0]    p_ch;
  logic              p_cfg;
  logic              p_vref;
  logic [1:0]        p_pd;
  logic              p_gx;
  logic [DW-1:0]     p_data;
  logic [NCH-1:0]    p_bits;
  logic              p_udac;
  logic              p_nv;

  localparam logic [CHW-1:0] LAST_CH = CHW'(NCH - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      mode     <= FM_FAST;
      ch       <= '0;
      udac     <= 1'b0;
      h_vref   <= 1'b0;
      h_pd     <= '0;
      h_gx     <= 1'b0;
      h_hi     <= '0;
      ack_q    <= 1'b0;
      pend_vld <= 1'b0;
      p_kind   <= CK_NONE;
      p_ch     <= '0;
      p_cfg    <= 1'b0;
      p_vref   <= 1'b0;
      p_pd     <= '0;
      p_gx     <= 1'b0;
      p_data   <= '0;
      p_bits   <= '0;
      p_udac   <= 1'b0;
      p_nv     <= 1'b0;
    end else if (stop_i) begin
      st       <= ST_IDLE;
      ack_q    <= 1'b0;
      pend_vld <= 1'b0;
    end else if (start_i) begin
      st       <= ST_ADDR;
      ack_q    <= 1'b0;
      pend_vld <= 1'b0;
    end else if (byte_vld_i) begin
      ack_q    <= 1'b0;
      pend_vld <= 1'b0;
      case (st)
        ST_ADDR: begin
          if (byte_i[7:4] == DEV_CODE && byte_i[3:1] == dev_addr_i && !byte_i[0]) begin
            ack_q <= 1'b1;
            st    <= ST_CMD;
          end else begin
            st    <= ST_SKIP;
          end
        end
        ST_CMD: begin
          if (byte_i[7:6] == 2'b00) begin
            mode  <= FM_FAST;
            ch    <= '0;
            h_pd  <= byte_i[5:4];
            h_hi  <= byte_i[HIW-1:0];
            ack_q <= 1'b1;
            st    <= ST_FLO;
          end else if (byte_i[7:3] == 5'b01000) begin
            mode  <= FM_MULTI;
            ch    <= byte_i[1 +: CHW];
            udac  <= byte_i[0];
            ack_q <= 1'b1;
            st    <= ST_CFG;
          end else if (byte_i[7:4] == 4'b0101) begin
            if (nv_busy_i) begin
              st <= ST_SKIP;
            end else begin
              mode  <= byte_i[3] ? FM_SINGLE : FM_SEQ;
              ch    <= byte_i[1 +: CHW];
              udac  <= byte_i[0];
              ack_q <= 1'b1;
              st    <= ST_CFG;
            end
          end else if (byte_i[7:5] == 3'b100 || byte_i[7:5] == 3'b110) begin
            ack_q    <= 1'b1;
            pend_vld <= 1'b1;
            p_kind   <= byte_i[6] ? CK_GAIN_ALL : CK_VREF_ALL;
            p_nv     <= 1'b0;
            for (int i = 0; i < NCH; i++) p_bits[i] <= byte_i[NCH-1-i];
            st       <= ST_SKIP;
          end else begin
            st <= ST_SKIP;
          end
        end
        ST_FHI: begin
          h_pd  <= byte_i[5:4];
          h_hi  <= byte_i[HIW-1:0];
          ack_q <= 1'b1;
          st    <= ST_FLO;
        end
        ST_FLO: begin
          ack_q    <= 1'b1;
          pend_vld <= 1'b1;
          p_kind   <= CK_CHAN;
          p_ch     <= ch;
          p_cfg    <= 1'b0;
          p_pd     <= h_pd;
          p_data   <= {h_hi, byte_i};
          p_udac   <= 1'b0;
          p_nv     <= 1'b0;
          if (ch == LAST_CH) begin
            st <= ST_SKIP;
          end else begin
            ch <= ch + 1'b1;
            st <= ST_FHI;
          end
        end
        ST_CFG: begin
          h_vref <= byte_i[7];
          h_pd   <= byte_i[6:5];
          h_gx   <= byte_i[4];
          h_hi   <= byte_i[HIW-1:0];
          ack_q  <= 1'b1;
          st     <= ST_LO;
        end
        ST_LO: begin
          ack_q    <= 1'b1;
          pend_vld <= 1'b1;
          p_kind   <= CK_CHAN;
          p_ch     <= ch;
          p_cfg    <= 1'b1;
          p_vref   <= h_vref;
          p_pd     <= h_pd;
          p_gx     <= h_gx;
          p_data   <= {h_hi, byte_i};
          p_udac   <= udac;
          p_nv     <= (mode == FM_SEQ) || (mode == FM_SINGLE);
          case (mode)
            FM_MULTI: st <= ST_MSEL;
            FM_SEQ: begin
              if (ch == LAST_CH) begin
                st <= ST_SKIP;
              end else begin
                ch <= ch + 1'b1;
                st <= ST_CFG;
              end
            end
            default: st <= ST_SKIP;
          endcase
        end
        ST_MSEL: begin
          ch    <= byte_i[1 +: CHW];
          udac  <= byte_i[0];
          ack_q <= 1'b1;
          st    <= ST_CFG;
        end
        default: st <= st;
      endcase
    end else if (ack_stb_i) begin
      pend_vld <= 1'b0;
    end
  end

  assign ack_o     = ack_q;
  assign commit_o  = ack_stb_i && pend_vld && !stop_i && !start_i && !byte_vld_i;
  assign cm_kind_o = p_kind;
  assign cm_ch_o   = p_ch;
  assign cm_cfg_o  = p_cfg;
  assign cm_vref_o = p_vref;
  assign cm_pd_o   = p_pd;
  assign cm_gx_o   = p_gx;
  assign cm_data_o = p_data;
  assign cm_bits_o = p_bits;
  assign cm_udac_o = p_udac;
  assign cm_nv_o   = p_nv;

endmodule

// File: rtl/dac_wcmd_regs.sv
module dac_wcmd_regs
  import dac_wcmd_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 12,
  localparam int CHW = $clog2(NCH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               commit_i,
  input  commit_kind_e       kind_i,
  input  logic [CHW-1:0]     ch_i,
  input  logic               cfg_i,
  input  logic               vref_i,
  input  logic [1:0]         pd_i,
  input  logic               gx_i,
  input  logic [DW-1:0]      data_i,
  input  logic [NCH-1:0]     bits_i,
  input  logic               udac_i,
  output logic [NCH-1:0]     vref_o,
  output logic [NCH-1:0]     gain_o,
  output logic [2*NCH-1:0]   pd_o,
  output logic [NCH*DW-1:0]  code_o,
  output logic [NCH-1:0]     upd_req_o
);

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic           vref_q;
    logic           gx_q;
    logic [1:0]     pd_q;
    logic [DW-1:0]  code_q;
    logic           upd_q;
    logic           hit;

    assign hit = commit_i && (kind_i == CK_CHAN) && (ch_i == CHW'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        vref_q <= 1'b0;
        gx_q   <= 1'b0;
        pd_q   <= '0;
        code_q <= '0;
        upd_q  <= 1'b0;
      end else begin
        upd_q <= 1'b0;
        if (hit) begin
          pd_q   <= pd_i;
          code_q <= data_i;
          upd_q  <= !udac_i;
          if (cfg_i) begin
            vref_q <= vref_i;
            gx_q   <= gx_i;
          end
        end else if (commit_i && kind_i == CK_VREF_ALL) begin
          vref_q <= bits_i[g];
          upd_q  <= 1'b1;
        end else if (commit_i && kind_i == CK_GAIN_ALL) begin
          gx_q   <= bits_i[g];
          upd_q  <= 1'b1;
        end
      end
    end

    assign vref_o[g]          = vref_q;
    assign gain_o[g]          = gx_q;
    assign pd_o[2*g +: 2]     = pd_q;
    assign code_o[g*DW +: DW] = code_q;
    assign upd_req_o[g]       = upd_q;
  end

endmodule

// File: rtl/dac_wcmd_nvreq.sv
module dac_wcmd_nvreq
  import dac_wcmd_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 12,
  localparam int CHW = $clog2(NCH),
  localparam int NVW = DW + 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               commit_i,
  input  commit_kind_e       kind_i,
  input  logic               nv_i,
  input  logic [CHW-1:0]     ch_i,
  input  logic               vref_i,
  input  logic [1:0]         pd_i,
  input  logic               gx_i,
  input  logic [DW-1:0]      data_i,
  output logic               nv_wr_o,
  output logic [CHW-1:0]     nv_ch_o,
  output logic [NVW-1:0]     nv_word_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      nv_wr_o   <= 1'b0;
      nv_ch_o   <= '0;
      nv_word_o <= '0;
    end else begin
      nv_wr_o <= 1'b0;
      if (commit_i && kind_i == CK_CHAN && nv_i) begin
        nv_wr_o   <= 1'b1;
        nv_ch_o   <= ch_i;
        nv_word_o <= {vref_i, pd_i, gx_i, data_i};
      end
    end
  end

endmodule

// File: rtl/dac_wcmd_dec.sv
module dac_wcmd_dec
  import dac_wcmd_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 12,
  parameter logic [3:0] DEV_CODE = 4'b1100,
  localparam int CHW = $clog2(NCH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2:0]         dev_addr_i,
  input  logic               nv_busy_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               byte_vld_i,
  input  logic [7:0]         byte_i,
  input  logic               ack_stb_i,
  output logic               ack_o,
  output logic [NCH-1:0]     vref_o,
  output logic [NCH-1:0]     gain_o,
  output logic [2*NCH-1:0]   pd_o,
  output logic [NCH*DW-1:0]  code_o,
  output logic [NCH-1:0]     upd_req_o,
  output logic               nv_wr_o,
  output logic [CHW-1:0]     nv_ch_o,
  output logic [DW+3:0]      nv_word_o
);

  logic           commit;
  commit_kind_e   cm_kind;
  logic [CHW-1:0] cm_ch;
  logic           cm_cfg;
  logic           cm_vref;
  logic [1:0]     cm_pd;
  logic           cm_gx;
  logic [DW-1:0]  cm_data;
  logic [NCH-1:0] cm_bits;
  logic           cm_udac;
  logic           cm_nv;

  dac_wcmd_fsm #(.NCH(NCH), .DW(DW), .DEV_CODE(DEV_CODE)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .dev_addr_i (dev_addr_i),
    .nv_busy_i  (nv_busy_i),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .byte_vld_i (byte_vld_i),
    .byte_i     (byte_i),
    .ack_stb_i  (ack_stb_i),
    .ack_o      (ack_o),
    .commit_o   (commit),
    .cm_kind_o  (cm_kind),
    .cm_ch_o    (cm_ch),
    .cm_cfg_o   (cm_cfg),
    .cm_vref_o  (cm_vref),
    .cm_pd_o    (cm_pd),
    .cm_gx_o    (cm_gx),
    .cm_data_o  (cm_data),
    .cm_bits_o  (cm_bits),
    .cm_udac_o  (cm_udac),
    .cm_nv_o    (cm_nv)
  );

  dac_wcmd_regs #(.NCH(NCH), .DW(DW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .commit_i  (commit),
    .kind_i    (cm_kind),
    .ch_i      (cm_ch),
    .cfg_i     (cm_cfg),
    .vref_i    (cm_vref),
    .pd_i      (cm_pd),
    .gx_i      (cm_gx),
    .data_i    (cm_data),
    .bits_i    (cm_bits),
    .udac_i    (cm_udac),
    .vref_o    (vref_o),
    .gain_o    (gain_o),
    .pd_o      (pd_o),
    .code_o    (code_o),
    .upd_req_o (upd_req_o)
  );

  dac_wcmd_nvreq #(.NCH(NCH), .DW(DW)) u_nv (
    .clk       (clk),
    .rst       (rst),
    .commit_i  (commit),
    .kind_i    (cm_kind),
    .nv_i      (cm_nv),
    .ch_i      (cm_ch),
    .vref_i    (cm_vref),
    .pd_i      (cm_pd),
    .gx_i      (cm_gx),
    .data_i    (cm_data),
    .nv_wr_o   (nv_wr_o),
    .nv_ch_o   (nv_ch_o),
    .nv_word_o (nv_word_o)
  );

endmodule

// File: rtl/dac_wcmd_dec_chk.sv
module dac_wcmd_dec_chk #(
  parameter int NCH = 4,
  parameter int DW  = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               stop_i,
  input logic               byte_vld_i,
  input logic               ack_stb_i,
  input logic               ack_o,
  input logic [NCH*DW-1:0]  code_o,
  input logic [NCH-1:0]     vref_o,
  input logic [NCH-1:0]     upd_req_o,
  input logic               nv_wr_o
);

  // R12
  code_commit_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(code_o) |-> $past(ack_stb_i));

  // R7
  vref_commit_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(vref_o) |-> $past(ack_stb_i));

  // R5
  nv_wr_chk: assert property (@(posedge clk) disable iff (rst)
    nv_wr_o |-> $past(ack_stb_i));

  // R9
  upd_req_chk: assert property (@(posedge clk) disable iff (rst)
    (|upd_req_o) |-> $past(ack_stb_i));

  // R2
  ack_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_o) |-> $past(byte_vld_i));

  // R10
  stop_ack_chk: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> !ack_o);

endmodule

bind dac_wcmd_dec dac_wcmd_dec_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .stop_i     (stop_i),
  .byte_vld_i (byte_vld_i),
  .ack_stb_i  (ack_stb_i),
  .ack_o      (ack_o),
  .code_o     (code_o),
  .vref_o     (vref_o),
  .upd_req_o  (upd_req_o),
  .nv_wr_o    (nv_wr_o)
);

// File: tb/test_dac_wcmd_dec.sv
module test_dac_wcmd_dec;

  localparam int NCH = 4;
  localparam int DW  = 12;
  localparam logic [7:0] ADDR_W = 8'hCA;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [2:0]        dev_addr = 3'b101;
  logic              nv_busy = 1'b0;
  logic              start = 1'b0;
  logic              stop = 1'b0;
  logic              bvld = 1'b0;
  logic [7:0]        bdat = 8'h00;
  logic              astb = 1'b0;
  logic              ack;
  logic [NCH-1:0]    vref;
  logic [NCH-1:0]    gain;
  logic [2*NCH-1:0]  pd;
  logic [NCH*DW-1:0] code;
  logic [NCH-1:0]    upd;
  logic              nv_wr;
  logic [1:0]        nv_ch;
  logic [DW+3:0]     nv_word;

  int checks = 0;
  int errors = 0;

  logic [NCH-1:0]    e_vref = '0;
  logic [NCH-1:0]    e_gain = '0;
  logic [2*NCH-1:0]  e_pd   = '0;
  logic [NCH*DW-1:0] e_code = '0;

  logic [NCH-1:0]    s_upd;
  logic              s_nv;
  logic [1:0]        s_nv_ch;
  logic [DW+3:0]     s_nv_word;

  always #2 clk = ~clk;

  dac_wcmd_dec #(.NCH(NCH), .DW(DW)) i_dac_wcmd_dec (
    .clk        (clk),
    .rst        (rst),
    .dev_addr_i (dev_addr),
    .nv_busy_i  (nv_busy),
    .start_i    (start),
    .stop_i     (stop),
    .byte_vld_i (bvld),
    .byte_i     (bdat),
    .ack_stb_i  (astb),
    .ack_o      (ack),
    .vref_o     (vref),
    .gain_o     (gain),
    .pd_o       (pd),
    .code_o     (code),
    .upd_req_o  (upd),
    .nv_wr_o    (nv_wr),
    .nv_ch_o    (nv_ch),
    .nv_word_o  (nv_word)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_regs(input string tag);
    chk({tag, " vref"}, 64'(vref), 64'(e_vref));
    chk({tag, " gain"}, 64'(gain), 64'(e_gain));
    chk({tag, " pd"},   64'(pd),   64'(e_pd));
    chk({tag, " code"}, 64'(code), 64'(e_code));
  endtask

  task automatic set_ch(input int c, input logic full, input logic v, input logic [1:0] p,
                        input logic g, input logic [11:0] d);
    e_pd[2*c +: 2]    = p;
    e_code[c*DW +: DW] = d;
    if (full) begin
      e_vref[c] = v;
      e_gain[c] = g;
    end
  endtask

  task automatic do_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk) stop = 1'b1;
    @(negedge clk) stop = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input logic exp_ack, input string tag);
    @(negedge clk) begin bvld = 1'b1; bdat = b; end
    @(negedge clk) begin
      bvld = 1'b0;
      chk({tag, " ack"}, 64'(ack), 64'(exp_ack));
      astb = 1'b1;
    end
    @(negedge clk) begin
      astb = 1'b0;
      s_upd = upd; s_nv = nv_wr; s_nv_ch = nv_ch; s_nv_word = nv_word;
    end
  endtask

  task automatic t_reset();
    chk_regs("R1 reset");
    chk("R1 reset ack", 64'(ack), 0);
    chk("R1 reset upd", 64'(upd), 0);
    chk("R1 reset nv", 64'(nv_wr), 0);
  endtask

  task automatic t_addr();
    do_start();
    send(8'hC2, 1'b0, "R2 wrong addr");
    send(8'h0F, 1'b0, "R2 after wrong addr");
    send(8'hFF, 1'b0, "R2 after wrong addr lo");
    do_stop();
    do_start();
    send(8'hCB, 1'b0, "R2 read bit");
    send(8'h8F, 1'b0, "R2 after read bit");
    do_stop();
    chk_regs("R2 no change");
  endtask

  task automatic t_vref_gain();
    do_start();
    send(ADDR_W, 1'b1, "R2 match");
    send(8'h8A, 1'b1, "R7 vref cmd");
    e_vref = 4'b0101;
    chk("R7 upd all", 64'(s_upd), 64'hF);
    chk("R7 no nv", 64'(s_nv), 0);
    chk_regs("R7 vref");
    do_stop();
    do_start();
    send(ADDR_W, 1'b1, "R2 match");
    send(8'hC5, 1'b1, "R8 gain cmd");
    e_gain = 4'b1010;
    chk("R8 upd all", 64'(s_upd), 64'hF);
    chk_regs("R8 gain");
    do_stop();
  endtask

  task automatic t_fast();
    logic [7:0] hi [4] = '{8'h1A, 8'h23, 8'h06, 8'h3F};
    logic [7:0] lo [4] = '{8'hBC, 8'h45, 8'h78, 8'hFF};
    do_start();
    send(ADDR_W, 1'b1, "R2 match");
    for (int c = 0; c < 4; c++) begin
      send(hi[c], 1'b1, "R3 fast hi");
      chk("R3 no commit on hi", 64'(s_upd), 0);
      send(lo[c], 1'b1, "R3 fast lo");
      set_ch(c, 1'b0, 1'b0, hi[c][5:4], 1'b0, {hi[c][3:0], lo[c]});
      chk("R3 fast upd", 64'(s_upd), 64'(1 << c));
      chk("R3 fast no nv", 64'(s_nv), 0);
      chk_regs("R3 fast regs");
    end
    send(8'h00, 1'b0, "R3 fast after D");
    do_stop();
  endtask

  task automatic t_multi();
    do_start();
    send(ADDR_W, 1'b1, "R2 match");
    send(8'h43, 1'b1, "R4 multi cmd");
    send(8'hD2, 1'b1, "R4 multi cfg");
    @(negedge clk) begin bvld = 1'b1; bdat = 8'h34; end
    @(negedge clk) bvld = 1'b0;
    repeat (3) @(negedge clk);
    chk_regs("R12 held before ack");
    chk("R12 no upd before ack", 64'(upd), 0);
    astb = 1'b1;
    @(negedge clk) begin astb = 1'b0; s_upd = upd; s_nv = nv_wr; end
    set_ch(1, 1'b1, 1'b1, 2'b10, 1'b1, 12'h234);
    chk_regs("R4 multi B");
    chk("R9 udac set no upd", 64'(s_upd), 0);
    chk("R4 multi no nv", 64'(s_nv), 0);
    send(8'h06, 1'b1, "R4 multi reselect");
    send(8'h01, 1'b1, "R4 multi cfg2");
    send(8'h11, 1'b1, "R4 multi lo2");
    set_ch(3, 1'b1, 1'b0, 2'b00, 1'b0, 12'h111);
    chk_regs("R4 multi D");
    chk("R9 udac clear upd", 64'(s_upd), 64'h8);
    do_stop();
  endtask

  task automatic t_busy();
    nv_busy = 1'b1;
    do_start();
    send(ADDR_W, 1'b1, "R2 match");
    send(8'h54, 1'b0, "R11 seq busy");
    send(8'h9F, 1'b0, "R11 after busy");
    send(8'hEE, 1'b0, "R11 after busy lo");
    do_stop();
    do_start();
    send(ADDR_W, 1'b1, "R2 match");
    send(8'h59, 1'b0, "R11 single busy");
    do_stop();
    chk_regs("R11 busy no change");
    do_start();
    send(ADDR_W, 1'b1, "R2 match");
    send(8'h40, 1'b1, "R11 multi while busy");
    send(8'h80, 1'b1, "R11 multi cfg");
    send(8'h01, 1'b1, "R11 multi lo");
    set_ch(0, 1'b1, 1'b1, 2'b00, 1'b0, 12'h001);
    chk_regs("R11 multi commit");
    chk("R11 multi no nv", 64'(s_nv), 0);
    do_stop();
    nv_busy = 1'b0;
  endtask

  task automatic t_seq();
    do_start();
    send(ADDR_W, 1'b1, "R2 match");
    send(8'h54, 1'b1, "R5 seq cmd");
    send(8'h9F, 1'b1, "R5 seq cfg C");
    send(8'hEE, 1'b1, "R5 seq lo C");
    set_ch(2, 1'b1, 1'b1, 2'b00, 1'b1, 12'hFEE);
    chk_regs("R5 seq C");
    chk("R5 nv C", 64'(s_nv), 1);
    chk("R5 nv ch C", 64'(s_nv_ch), 2);
    chk("R5 nv word C", 64'(s_nv_word), 64'h9FEE);
    chk("R9 seq upd C", 64'(s_upd), 64'h4);
    send(8'h65, 1'b1, "R5 seq cfg D");
    send(8'h55, 1'b1, "R5 seq lo D");
    set_ch(3, 1'b1, 1'b0, 2'b11, 1'b0, 12'h555);
    chk_regs("R5 seq D");
    chk("R5 nv ch D", 64'(s_nv_ch), 3);
    chk("R5 nv word D", 64'(s_nv_word), 64'h6555);
    send(8'h12, 1'b0, "R5 seq past D");
    do_stop();
  endtask

  task automatic t_single();
    do_start();
    send(ADDR_W, 1'b1, "R2 match");
    send(8'h59, 1'b1, "R6 single cmd");
    send(8'h47, 1'b1, "R6 single cfg");
    send(8'h77, 1'b1, "R6 single lo");
    set_ch(0, 1'b1, 1'b0, 2'b10, 1'b0, 12'h777);
    chk_regs("R6 single A");
    chk("R6 nv", 64'(s_nv), 1);
    chk("R6 nv ch", 64'(s_nv_ch), 0);
    chk("R6 nv word", 64'(s_nv_word), 64'h4777);
    chk("R9 single udac upd", 64'(s_upd), 0);
    send(8'h47, 1'b0, "R6 single extra");
    do_stop();
  endtask

  task automatic t_abort();
    do_start();
    send(ADDR_W, 1'b1, "R2 match");
    send(8'h42, 1'b1, "R10 multi cmd");
    send(8'hFF, 1'b1, "R10 multi cfg");
    do_stop();
    chk_regs("R10 stop abandons");
    chk("R10 stop no upd", 64'(upd), 0);
    do_start();
    send(ADDR_W, 1'b1, "R2 match");
    send(8'h3F, 1'b1, "R10 fast hi");
    do_start();
    chk_regs("R10 restart abandons");
    send(ADDR_W, 1'b1, "R10 restart addr");
    send(8'h88, 1'b1, "R10 restart vref cmd");
    e_vref = 4'b0001;
    chk_regs("R10 after restart");
    do_stop();
  endtask

  task automatic t_badcmd();
    do_start();
    send(ADDR_W, 1'b1, "R2 match");
    send(8'hE0, 1'b0, "R13 bad cmd 111");
    send(8'h00, 1'b0, "R13 after bad");
    do_stop();
    do_start();
    send(ADDR_W, 1'b1, "R2 match");
    send(8'h48, 1'b0, "R13 bad cmd 01001");
    send(8'h8F, 1'b0, "R13 after bad 2");
    do_stop();
    chk_regs("R13 no change");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_addr();
    t_vref_gain();
    t_fast();
    t_multi();
    t_busy();
    t_seq();
    t_single();
    t_abort();
    t_badcmd();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule